// File: doc/BRIEF.md
# Prescaled PWM Time Base

This block generates two edge-aligned pulse-width-modulated outputs from one shared up-counting time base. The counter does not move on every system clock. It moves on a tick produced by two prescalers in cascade. The first prescaler divides by a power of two. The second divides by one or by an even number.

Software sets up the block through a narrow write port. This port loads the wrap point (period), two compare values, the prescaler codes, the action codes for each output, and a run bit. On every tick, each output checks two events: the counter being at zero, and the counter matching that output's compare value. Each event selects a 2-bit action that leaves the output unchanged, forces it low, forces it high, or toggles it.

Typical use: set the zero action to force-high and the compare action to force-low. The compare value then sets the duty cycle directly, from fully off to fully on.

Top module: `pwm_timebase`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_addr`, and the new value takes effect from the next clock. The address map is: 0 = period, 1 = compare A, 2 = compare B, 3 = prescaler codes, 4 = action codes, 5 = run (bit 0). Writes to addresses 6 and 7 change nothing.
- R2: The prescaler register holds the power-of-two code in bits [2:0] and the even-divide code in bits [5:3]. A tick occurs once every 2^c1 × d2 clocks, where d2 = 1 when the even-divide code is 0 and d2 = 2 × code otherwise.
- R3: While running, `count` advances by one only on a tick. It counts from 0 up to the period value and then returns to 0, so one output cycle lasts period + 1 ticks.
- R4: If the period is lowered below the current count, the next tick returns `count` to 0.
- R5: The action codes are 0 = no change, 1 = force low, 2 = force high, 3 = toggle. In the action register, bits [1:0] hold the zero action of output A and bits [3:2] hold its compare action. Bits [5:4] and [7:6] hold the same two actions for output B.
- R6: On a tick, a zero event occurs when `count` is 0, and a compare event occurs when `count` equals that output's compare value. Output A uses compare A and output B uses compare B. The output changes on the same clock edge at which `count` advances.
- R7: When a zero event and a compare event happen on the same tick, the compare action is applied and the zero action is ignored.
- R8: With zero action 2 and compare action 1, the output is high for `cmp` ticks of each period + 1 ticks. A compare of 0 keeps the output low, and a compare of period + 1 keeps it high.
- R9: While the run bit is 0, `count` is 0, both outputs are low, and the prescaler phase is cleared. After reset, all registers are 0.
- R10: Any write to the prescaler register restarts the prescaler phase. The first tick at the new ratio then comes a full divide interval after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Time-base counter value |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The bench builds the block with an 8-bit counter and 3-bit prescaler codes. These widths keep periods short, so many full wraps fit in a short run, while divide ratios up to 1792 remain reachable. The small width also lets a compare value of period + 1 be written, which holds the output fully on. It also lets the period be lowered under a running count so the wrap-from-above case can be checked.

// File: rtl/pwm_tb_pkg.sv
// Shared types and register addresses for the prescaled PWM time base.
// Assumes the data word is at least 8 bits wide so the action fields fit.
package pwm_tb_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    localparam logic [2:0] ADDR_PERIOD = 3'd0;
    localparam logic [2:0] ADDR_CMPA   = 3'd1;
    localparam logic [2:0] ADDR_CMPB   = 3'd2;
    localparam logic [2:0] ADDR_PRESC  = 3'd3;
    localparam logic [2:0] ADDR_ACT    = 3'd4;
    localparam logic [2:0] ADDR_RUN    = 3'd5;

    // Resolve one action code against the current output level.
    function automatic logic apply_act(input logic cur, input act_e a);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Two-stage clock-enable generator.
// Stage one divides by 2**ls_code.
// Stage two divides by 1 (code 0) or by 2*hs_code.
// Both stages share one phase counter that runs to their product.
// Assumes the codes change only together with a restart pulse.
module pwm_prescaler #(
    parameter int LS_W = 3,
    parameter int HS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [LS_W-1:0] ls_code,
    input  logic [HS_W-1:0] hs_code,
    output logic            tick
);
    localparam int PRE_W = (1 << LS_W) - 1 + HS_W + 1;

    logic [PRE_W-1:0] ls_div, hs_div, last, pre_cnt;

    // Terminal phase value for the current pair of codes.
    always_comb begin
        ls_div = PRE_W'(1) << ls_code;
        hs_div = (hs_code == '0) ? PRE_W'(1) : PRE_W'({hs_code, 1'b0});
        last   = PRE_W'(ls_div * hs_div) - PRE_W'(1);
    end

    assign tick = run && (pre_cnt == last);

    // Phase counter: cleared when idle, on restart and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || tick) pre_cnt <= '0;
        else                                   pre_cnt <= pre_cnt + PRE_W'(1);
    end

    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= last);
    p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pre_cnt == '0);
endmodule

// File: rtl/pwm_counter.sv
// Up-counting time-base counter.
// Advances on the prescaled tick and returns to 0 once it has
// reached or passed the period value.
// Held at 0 while the run bit is low.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count
);
    // Count register: hold, advance or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)        count <= '0;
        else if (tick) begin
            if (count >= period)   count <= '0;
            else                   count <= count + CNT_W'(1);
        end
    end

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0);
    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count));
    p_wrap_from_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count >= period) |=> count == '0);
endmodule

// File: rtl/pwm_action_out.sv
// Action qualifier for one output.
// On a tick it applies the compare action when the count matches
// the compare value; otherwise it applies the zero action when the
// count is 0. Driven low while the run bit is low.
module pwm_action_out
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  act_e             zro_act,
    input  act_e             cmp_act,
    output logic             pwm
);
    logic ev_zero, ev_cmp;

    assign ev_zero = tick && (count == '0);
    assign ev_cmp  = tick && (count == cmp);

    // Output level register, compare event ahead of zero event.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pwm <= 1'b0;
        else if (ev_cmp)    pwm <= apply_act(pwm, cmp_act);
        else if (ev_zero)   pwm <= apply_act(pwm, zro_act);
    end

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm);
    p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(pwm));
    p_cmp_wins_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ev_cmp && cmp_act == ACT_LOW) |=> !pwm);
    p_cmp_wins_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ev_cmp && cmp_act == ACT_HIGH) |=> pwm);
endmodule

// File: rtl/pwm_timebase.sv
// Prescaled PWM time base: register file, prescaler, counter and two
// action-qualified outputs.
// Register writes apply on the next clock, with no shadowing.
// Assumes CNT_W >= 8 and CNT_W >= LS_W + HS_W.
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LS_W  = 3,
    parameter int HS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             pwm_a,
    output logic             pwm_b
);
    localparam int NOUT = 2;

    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cmp_q [NOUT];
    logic [LS_W-1:0]  ls_q;
    logic [HS_W-1:0]  hs_q;
    logic [7:0]       act_q;
    logic             run_q;
    logic             presc_wr;
    logic             tick;
    logic [NOUT-1:0]  pwm_vec;

    assign presc_wr = wr_en && (wr_addr == ADDR_PRESC);

    // Register file loaded through the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            cmp_q[0] <= '0;
            cmp_q[1] <= '0;
            ls_q     <= '0;
            hs_q     <= '0;
            act_q    <= '0;
            run_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD: period_q <= wr_data;
                ADDR_CMPA:   cmp_q[0] <= wr_data;
                ADDR_CMPB:   cmp_q[1] <= wr_data;
                ADDR_PRESC: begin
                    ls_q <= wr_data[LS_W-1:0];
                    hs_q <= wr_data[LS_W +: HS_W];
                end
                ADDR_ACT:    act_q <= wr_data[7:0];
                ADDR_RUN:    run_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    pwm_prescaler #(.LS_W(LS_W), .HS_W(HS_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (presc_wr),
        .ls_code (ls_q),
        .hs_code (hs_q),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .tick   (tick),
        .period (period_q),
        .count  (count)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        pwm_action_out #(.CNT_W(CNT_W)) u_aq (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_q),
            .tick    (tick),
            .count   (count),
            .cmp     (cmp_q[g]),
            .zro_act (act_e'(act_q[4*g +: 2])),
            .cmp_act (act_e'(act_q[4*g+2 +: 2])),
            .pwm     (pwm_vec[g])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

    p_write_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RUN) |=> run_q == $past(wr_data[0]));
endmodule

// File: tb/pwm_timebase_tb.sv
// Bench for pwm_timebase. A behavioural model runs in parallel with the
// design and is compared against it on every falling clock edge.
module pwm_timebase_tb;
    localparam int CNT_W = 8;
    localparam int LS_W  = 3;
    localparam int HS_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count;
    logic             pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    string tag = "R9";

    always #4 clk = ~clk;

    pwm_timebase #(.CNT_W(CNT_W), .LS_W(LS_W), .HS_W(HS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // Behavioural reference state.
    int m_prd, m_ca, m_cb, m_ls, m_hs, m_act, m_run;
    int m_pre, m_cnt, m_oa, m_ob;

    function automatic int act_res(int cur, int code);
        case (code)
            1: return 0;
            2: return 1;
            3: return 1 - cur;
            default: return cur;
        endcase
    endfunction

    function automatic int out_next(int cur, int cnt, int cmp, int zc, int cc);
        if (cnt == cmp) return act_res(cur, cc);
        if (cnt == 0)   return act_res(cur, zc);
        return cur;
    endfunction

    // Model update at each rising edge from pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prd = 0; m_ca = 0; m_cb = 0; m_ls = 0; m_hs = 0; m_act = 0;
            m_run = 0; m_pre = 0; m_cnt = 0; m_oa = 0; m_ob = 0;
        end else begin
            int div;
            bit tk;
            div = (1 << m_ls) * ((m_hs == 0) ? 1 : 2 * m_hs);
            tk = (m_run != 0) && (m_pre == div - 1);
            if (m_run == 0) begin
                m_pre = 0; m_cnt = 0; m_oa = 0; m_ob = 0;
            end else begin
                if (tk) begin
                    m_oa = out_next(m_oa, m_cnt, m_ca, m_act & 3, (m_act >> 2) & 3);
                    m_ob = out_next(m_ob, m_cnt, m_cb, (m_act >> 4) & 3, (m_act >> 6) & 3);
                    m_cnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
                end
                if ((wr_en && wr_addr == 3'd3) || tk) m_pre = 0;
                else m_pre = m_pre + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_prd = int'(wr_data);
                    3'd1: m_ca  = int'(wr_data);
                    3'd2: m_cb  = int'(wr_data);
                    3'd3: begin m_ls = int'(wr_data) & 7; m_hs = (int'(wr_data) >> 3) & 7; end
                    3'd4: m_act = int'(wr_data);
                    3'd5: m_run = int'(wr_data) & 1;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare design against model away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check(tag, "count", int'(count), m_cnt);
            check(tag, "pwm_a", int'(pwm_a), m_oa);
            check(tag, "pwm_b", int'(pwm_b), m_ob);
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R9: reset state.
        check("R9", "reset count", int'(count), 0);
        check("R9", "reset pwm_a", int'(pwm_a), 0);
        check("R9", "reset pwm_b", int'(pwm_b), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;

        tag = "R1 R3 R6 R8";
        wr(3'd0, 9); wr(3'd1, 4); wr(3'd2, 7);
        wr(3'd3, 0); wr(3'd4, 8'h66); wr(3'd5, 1);
        idle(50);

        tag = "R8 edges";
        wr(3'd1, 0); wr(3'd2, 10);
        idle(40);

        tag = "R5 codes";
        wr(3'd1, 4); wr(3'd2, 6); wr(3'd4, 8'h93);
        idle(40);
        wr(3'd4, 8'h2C);
        idle(30);

        tag = "R7 coincide";
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd4, 8'h6E);
        idle(40);

        tag = "R2 divide";
        wr(3'd1, 3); wr(3'd2, 5); wr(3'd4, 8'h66);
        wr(3'd3, 8'h02);
        idle(200);
        wr(3'd3, 8'h19);
        idle(500);
        wr(3'd3, 8'h07);
        idle(300);

        tag = "R10 restart";
        wr(3'd3, 8'h02);
        for (int i = 0; i < 5; i++) begin
            wr(3'd3, 8'h02);
            idle(2);
        end
        idle(30);

        tag = "R4 shrink";
        wr(3'd3, 0); wr(3'd0, 200);
        idle(60);
        wr(3'd0, 20);
        idle(40);

        tag = "R1 unused";
        wr(3'd6, 8'hFF); wr(3'd7, 8'hA5);
        idle(30);

        tag = "R9 run off";
        wr(3'd5, 0);
        idle(10);
        wr(3'd5, 1);
        idle(30);

        chk_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule